// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Flag

This block is the integer arithmetic and logic stage of a simple load/store RISC pipeline. Each cycle it takes two 32-bit operands, a 5-bit constant shift count and a 4-bit operation code. On the next rising clock edge it presents a 32-bit result and a one-bit overflow flag. It covers modular add and subtract, the four bitwise functions, left and right shifts by a constant or by a register amount, and signed and unsigned less-than compares.

Add and subtract come in two flavours that share one adder. The trapping flavour raises the overflow flag when the two's-complement result does not fit in 32 bits. The non-trapping flavour never raises it. The result is driven even when the flag is raised. Suppressing the register write and taking the exception are left to the surrounding pipeline. Immediates reach `b_i` already sign-extended by the decoder. This holds for the non-trapping add-immediate as well.

Top module: `int_alu_trap`

## Requirements
- R1: While `rst` is high at a rising edge, the registered outputs become `result_o` = 0 and `ovf_o` = 0.
- R2: The outputs for a set of inputs appear exactly one rising edge after those inputs are sampled. Before that edge, the outputs keep their previous values.
- R3: op 0 (trapping add) and op 1 (plain add) give a_i + b_i mod 2^32. op 2 (trapping subtract) and op 3 (plain subtract) give a_i - b_i mod 2^32.
- R4: `ovf_o` is 1 for op 0 and op 2 exactly when the signed result lies outside [-2^31, 2^31-1]. `result_o` still carries the wrapped value in that case.
- R5: `ovf_o` is 0 for every op other than 0 and 2. This includes op 1 and op 3 with operands that overflow.
- R6: op 4 gives a AND b, op 5 gives a OR b, op 6 gives a XOR b, and op 7 gives the inverse of (a OR b).
- R7: op 8 shifts a_i left, op 9 shifts it right logically (zero fill), and op 10 shifts it right arithmetically (copies of bit 31 fill the vacated bits). All three shift by `shamt_i`. A count of 0 returns a_i unchanged.
- R8: ops 11, 12 and 13 are the left, logical-right and arithmetic-right shifts by b_i[4:0]. The upper bits of b_i and `shamt_i` have no effect on them.
- R9: op 14 returns 1 if a_i < b_i as signed numbers and 0 otherwise. op 15 does the same comparison as unsigned numbers. Bits 31..1 of the result are 0 for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (see R3 to R9) |
| a_i | input | 32 | First operand; the shifted value for shifts |
| b_i | input | 32 | Second operand; its low 5 bits are the variable shift count |
| shamt_i | input | 5 | Constant shift count |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
Some properties are checked on every cycle. The flag appears only after a trapping add or subtract. A flagged result has a sign bit that differs from the first operand's sign. Compare results are 0 or 1. Arithmetic right shifts keep the sign bit. A zero constant shift passes the operand through. Reset clears both outputs. The exact values come only from the bench's directed scenarios. These cover wrap at both signed limits, the same operands under the plain flavour, the four bitwise functions, fill bits for each shift kind, a variable count with junk in the upper bits, and compares that disagree between signed and unsigned. The bench scenarios also cover the one-edge latency.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDU = 4'd1,  OP_SUB  = 4'd2,  OP_SUBU = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_NOR  = 4'd7,
    OP_SLL  = 4'd8,  OP_SRL  = 4'd9,  OP_SRA  = 4'd10, OP_SLLV = 4'd11,
    OP_SRLV = 4'd12, OP_SRAV = 4'd13, OP_SLT  = 4'd14, OP_SLTU = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder: subtract adds the inverted operand plus one.
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] bx;
  logic [W:0]   full;

  assign bx    = b ^ {W{sub}};
  assign full  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];
  assign carry = full[W];
  // operands of equal sign producing a result of the other sign
  assign ovf   = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] res
);
  always_comb begin
    case (sel)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      2'd2:    res = a ^ b;
      default: res = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
// Log-stage barrel shifter; left shifts reuse the right path via bit reversal.
module alu_shifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   data,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stg [0:SHW];
  logic         fill;

  assign fill = arith & ~left & data[W-1];

  for (genvar k = 0; k < W; k++) begin : g_rev
    assign rev_in[k]  = data[W-1-k];
    assign rev_out[k] = stg[SHW][W-1-k];
  end

  assign stg[0] = left ? rev_in : data;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int S = 1 << i;
    assign stg[i+1] = amt[i] ? {{S{fill}}, stg[i][W-1:S]} : stg[i];
  end

  assign res = left ? rev_out : stg[SHW];
endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [W-1:0]   result_o,
  output logic           ovf_o
);
  alu_op_e      op;
  logic         is_sub, sh_var, sh_left, sh_arith;
  logic [SHW-1:0] sh_amt;
  logic [W-1:0] sum, lres, sres, res_n;
  logic         carry, ovf_raw, lt_s, lt_u, ovf_n;
  logic [W-1:0] result_q;
  logic         ovf_q;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  assign sh_var   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign sh_left  = (op == OP_SLL) || (op == OP_SLLV);
  assign sh_arith = (op == OP_SRA) || (op == OP_SRAV);
  assign sh_amt   = sh_var ? b_i[SHW-1:0] : shamt_i;

  alu_addsub #(.W(W)) u_add (
    .a(a_i), .b(b_i), .sub(is_sub), .sum(sum), .carry(carry), .ovf(ovf_raw)
  );

  alu_logic #(.W(W)) u_log (
    .a(a_i), .b(b_i), .sel(op_i[1:0]), .res(lres)
  );

  alu_shifter #(.W(W), .SHW(SHW)) u_shf (
    .data(a_i), .amt(sh_amt), .left(sh_left), .arith(sh_arith), .res(sres)
  );

  assign lt_s  = sum[W-1] ^ ovf_raw;
  assign lt_u  = ~carry;
  assign ovf_n = ovf_raw && ((op == OP_ADD) || (op == OP_SUB));

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:  res_n = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:     res_n = lres;
      OP_SLT:                            res_n = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                           res_n = {{(W-1){1'b0}}, lt_u};
      default:                           res_n = sres;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      result_q <= res_n;
      ovf_q    <= ovf_n;
    end
  end

  assign result_o = result_q;
  assign ovf_o    = ovf_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result_o == '0 && !ovf_o));

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !$past(rst)) |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_SUB));

  // R4
  flag_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !$past(rst)) |-> (result_o[W-1] != $past(a_i[W-1])));

  // R9
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU))
      |-> (result_o[W-1:1] == '0));

  // R7
  sra_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SRA || $past(op_i) == OP_SRAV))
      |-> (result_o[W-1] == $past(a_i[W-1])));

  // R7
  zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SLL && $past(shamt_i) == '0)
      |-> (result_o == $past(a_i)));
endmodule

// File: tb/sim_int_alu_trap.sv
`timescale 1ns/1ps
module sim_int_alu_trap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  int_alu_trap u0 (.clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
                   .shamt_i(shamt_i), .result_o(result_o), .ovf_o(ovf_o));

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    longint s;
    logic [31:0] r;
    logic v;
    v = 1'b0;
    case (op)
      0, 1: begin r = a + b; s = longint'($signed(a)) + longint'($signed(b)); end
      2, 3: begin r = a - b; s = longint'($signed(a)) - longint'($signed(b)); end
      default: begin r = '0; s = 0; end
    endcase
    if ((op == 0 || op == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648)) v = 1'b1;
    case (op)
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~(a | b);
      8: r = a << sh;
      9: r = a >> sh;
      10: r = $unsigned($signed(a) >>> sh);
      11: r = a << b[4:0];
      12: r = a >> b[4:0];
      13: r = $unsigned($signed(a) >>> b[4:0]);
      14: r = {31'd0, $signed(a) < $signed(b)};
      15: r = {31'd0, a < b};
      default: ;
    endcase
    return {v, r};
  endfunction

  task automatic check(input string req, input logic [31:0] r, input logic v,
                       input logic [31:0] er, input logic ev);
    n_chk++;
    if (r !== er || v !== ev) begin
      n_fail++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", req, r, v, er, ev);
    end
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] sh);
    logic [32:0] e;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    @(posedge clk); #1;
    e = model(op, a, b, sh);
    check(req, result_o, ovf_o, e[31:0], e[32]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    op_i = 4'd0; a_i = 32'h7FFF_FFFF; b_i = 32'h1; rst = 1'b1;
    @(posedge clk); #1;
    check("R1", result_o, ovf_o, 32'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_latency;
    run("R2", 4'd1, 32'd10, 32'd20, 5'd0);
    @(negedge clk);
    op_i = 4'd1; a_i = 32'd1; b_i = 32'd1;
    #1 check("R2", result_o, ovf_o, 32'd30, 1'b0);
    @(posedge clk); #1;
    check("R2", result_o, ovf_o, 32'd2, 1'b0);
  endtask

  task automatic t_arith;
    run("R4", 4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0);
    run("R4", 4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
    run("R3", 4'd0, 32'hFFFF_FFFF, 32'h1, 5'd0);
    run("R4", 4'd2, 32'h8000_0000, 32'h1, 5'd0);
    run("R4", 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run("R3", 4'd2, 32'd5, 32'd7, 5'd0);
    run("R5", 4'd1, 32'h7FFF_FFFF, 32'h1, 5'd0);
    run("R5", 4'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run("R3", 4'd3, 32'h0, 32'h1, 5'd0);
  endtask

  task automatic t_logic;
    for (int k = 4; k < 8; k++)
      run("R6", k[3:0], 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
  endtask

  task automatic t_shift;
    run("R7", 4'd10, 32'h8000_0001, 32'h0, 5'd4);
    run("R7", 4'd9,  32'h8000_0001, 32'h0, 5'd4);
    run("R7", 4'd8,  32'h8000_0001, 32'h0, 5'd4);
    run("R7", 4'd8,  32'hDEAD_BEEF, 32'h0, 5'd0);
    run("R7", 4'd10, 32'h8000_0000, 32'h0, 5'd31);
    run("R7", 4'd9,  32'h8000_0000, 32'h0, 5'd31);
    run("R8", 4'd11, 32'h0000_00F1, 32'hFFFF_FF04, 5'd7);
    run("R8", 4'd12, 32'hF000_0000, 32'hABCD_0E08, 5'd1);
    run("R8", 4'd13, 32'hF000_0000, 32'h1234_5608, 5'd30);
  endtask

  task automatic t_compare;
    run("R9", 4'd14, 32'hFFFF_FFFF, 32'h1, 5'd0);
    run("R9", 4'd15, 32'hFFFF_FFFF, 32'h1, 5'd0);
    run("R9", 4'd14, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    run("R9", 4'd15, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    run("R9", 4'd14, 32'd9, 32'd9, 5'd0);
    run("R9", 4'd15, 32'd3, 32'd9, 5'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: result=%h ovf=%b expected completion", result_o, ovf_o);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_latency;
    t_arith;
    t_logic;
    t_shift;
    t_compare;
    t_reset;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule